// File: doc/BRIEF.md
# Flash Page Programming Controller

This block stands between a processor's register and data buses and a flash-style memory target. Software fills a 128-byte page buffer through ordinary data writes while a buffer-enable control bit is set. The low seven address bits pick the byte in the page. The upper nine bits name the page that is to be programmed.

Programming cannot start from a single stray write. Software must write the key 5h into the upper nibble of the control register and then write Ah on the very next control write. Only then does the block issue a one-cycle command toward the memory space picked by a 2-bit space-select field. Space-select 11 does not program anything: the launch instead resets the page buffer to the erased value. A status register reports a broken key order and whether the buffer holds loaded data.

The memory target is represented by a command port. The target reads the buffered bytes through a byte-read port and answers with an acknowledge. The controller stays busy until that acknowledge arrives.

Top module: `flash_page_ctl`

## Requirements
- R1: After reset the status readback is 00h, the control readback is 00h, `busy` and `cmd_valid` are low, and every buffer byte reads FFh.
- R2: While control bit 0 (buffer enable) is set, a data write stores `dat_wdata` at buffer offset `dat_addr[6:0]`. It also records `dat_addr[15:7]` as the page and sets the buffer-loaded flag (status bit 0).
- R3: The buffer enable overrides the external-RAM select. `xram_wr` is high only for a data write with `xram_sel` set and buffer enable clear, and a data write with buffer enable clear leaves the buffer unchanged.
- R4: A control write with key field (bits 7:4) 5h arms the launch. If the next control write carries key Ah and its space field (bits 2:1) is not 11, then in the cycle after that write's edge `cmd_valid` is high, `cmd_space` holds that space field, `cmd_page` holds the recorded page, and the buffer-loaded flag is clear.
- R5: `cmd_valid` lasts exactly one cycle. `busy` rises with it and stays high until the edge at which `cmd_ack` is sampled high.
- R6: A control write with key Ah that is not directly preceded by an arming write sets the sequence-error flag (status bit 1) and issues no command.
- R7: A status write with bit 1 at 0 clears the sequence-error flag. A status write never sets either flag, and status bits 7:2 always read 0.
- R8: A successful launch clears the sequence-error flag.
- R9: A launch whose space field is 11 sets all 128 buffer bytes to FFh and clears the buffer-loaded flag. It issues no command and leaves `busy` low.
- R10: While armed, a control write whose key is neither 5h nor Ah sets the sequence-error flag and disarms. A repeated 5h restarts the arming without error.
- R11: While `busy` is high, data writes are ignored. A key-Ah write made during that time is refused, sets the sequence-error flag and issues no command.
- R12: A data write in the same cycle as a successful launch is dropped.
- R13: The control readback shows buffer enable in bit 0 and the space field in bits 2:1. Bits 7:3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data: key [7:4], space [2:1], buffer enable [0] |
| ctl_rdata | output | 8 | Control register readback |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 8 | Status write data; bit 1 at 0 clears the sequence error |
| sts_rdata | output | 8 | Status readback: sequence error [1], buffer loaded [0] |
| dat_wr | input | 1 | Data write strobe |
| dat_addr | input | 16 | Data write address |
| dat_wdata | input | 8 | Data write byte |
| xram_sel | input | 1 | External-RAM select for data writes |
| xram_wr | output | 1 | Data write forwarded to external RAM |
| cmd_valid | output | 1 | One-cycle program command |
| cmd_space | output | 2 | Target space of the command |
| cmd_page | output | 9 | Page number of the command |
| cmd_ack | input | 1 | Target has finished the command |
| busy | output | 1 | Command outstanding |
| rd_idx | input | 7 | Byte index for the target's buffer read |
| rd_data | output | 8 | Buffer byte at `rd_idx` |

## Verification
The same-cycle case that matters is a data write arriving in the cycle of the launching key-Ah write. That write could otherwise slip into the buffer after the command has captured the page, or set the loaded flag again as the launch clears it. The bench drives both strobes on one clock edge. It then checks that the command carries the earlier page, that the dropped byte still reads FFh, that a previously loaded byte is intact, and that the loaded flag reads 0. A second overlap happens when a launch is tried while the controller is busy. The bench judges it by the sequence-error flag and by the absence of a new command pulse.

// File: rtl/flash_pgm_pkg.sv
// Shared constants and types for the flash page programming controller.
// Assumes an 8-bit register interface with the key in the upper nibble.
package flash_pgm_pkg;

    localparam logic [3:0] KEY_ARM = 4'h5;
    localparam logic [3:0] KEY_GO  = 4'hA;

    typedef enum logic [1:0] {
        SPC_USER   = 2'b00,
        SPC_XROW   = 2'b01,
        SPC_SECURE = 2'b10,
        SPC_BUFCLR = 2'b11
    } space_e;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_ARMED = 1'b1
    } trk_state_e;

endpackage

// File: rtl/key_tracker.sv
// Two-write launch key tracker. A write with the arm key arms the tracker.
// A go-key write that follows immediately launches, unless busy is high.
// The tracker flags out-of-order keys and refused launches.
// Assumes ctl_wr is a single-cycle strobe qualified by the caller.
module key_tracker
    import flash_pgm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [3:0] key,
    input  logic       busy,
    output logic       launch,
    output logic       seq_err
);

    trk_state_e state_q, state_d;

    // Next-state and launch/error decode for each control write.
    always_comb begin
        state_d = state_q;
        launch  = 1'b0;
        seq_err = 1'b0;
        if (ctl_wr) begin
            if (key == KEY_ARM) begin
                state_d = TRK_ARMED;
            end else if (key == KEY_GO) begin
                state_d = TRK_IDLE;
                if (state_q == TRK_ARMED && !busy) begin
                    launch = 1'b1;
                end else begin
                    seq_err = 1'b1;
                end
            end else begin
                state_d = TRK_IDLE;
                if (state_q == TRK_ARMED) begin
                    seq_err = 1'b1;
                end
            end
        end
    end

    // Tracker state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TRK_IDLE;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/page_buffer.sv
// Page buffer of PAGE_BYTES bytes: one write port, one combinational
// read port, and a single-cycle fill to the erased value.
// Assumes the caller never asserts clr and wr_en in the same cycle
// with an intent to keep the write (clr wins).
module page_buffer #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [DATA_W-1:0] ERASED = '1;

    logic [DATA_W-1:0] mem [PAGE_BYTES];

    // Byte storage: reset and clear fill with the erased value.
    always_ff @(posedge clk) begin
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (!rst_n || clr) begin
                mem[i] <= ERASED;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                mem[i] <= wr_data;
            end
        end
    end

    // Combinational read for the memory target.
    assign rd_data = mem[rd_idx];

endmodule

// File: rtl/flash_status.sv
// Status flags: the sequence error and the buffer-loaded flag.
// A hardware set of the error beats both a software clear and a launch clear.
// Assumes launch and err_set are never high together (the key tracker
// guarantees this).
module flash_status (
    input  logic clk,
    input  logic rst_n,
    input  logic err_set,
    input  logic launch,
    input  logic sw_clr,
    input  logic byte_loaded,
    output logic seq_err,
    output logic loaded
);

    // Sequence-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n)               seq_err <= 1'b0;
        else if (err_set)         seq_err <= 1'b1;
        else if (launch || sw_clr) seq_err <= 1'b0;
    end

    // Buffer-loaded flag: set by the first accepted byte, cleared by a launch.
    always_ff @(posedge clk) begin
        if (!rst_n)           loaded <= 1'b0;
        else if (launch)      loaded <= 1'b0;
        else if (byte_loaded) loaded <= 1'b1;
    end

endmodule

// File: rtl/cmd_issuer.sv
// Issues the one-cycle program command and holds busy until acknowledged.
// Assumes launch is only asserted while busy is low.
module cmd_issuer
    import flash_pgm_pkg::*;
#(
    parameter int PAGE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic [1:0]        space,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              cmd_ack,
    output logic              cmd_valid,
    output logic [1:0]        cmd_space,
    output logic [PAGE_W-1:0] cmd_page,
    output logic              busy
);

    logic issue;
    assign issue = launch && (space != SPC_BUFCLR);

    // Command pulse and captured command fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_space <= '0;
            cmd_page  <= '0;
        end else begin
            cmd_valid <= issue;
            if (issue) begin
                cmd_space <= space;
                cmd_page  <= page_in;
            end
        end
    end

    // Busy window from the command until the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)              busy <= 1'b0;
        else if (issue)          busy <= 1'b1;
        else if (busy && cmd_ack) busy <= 1'b0;
    end

endmodule

// File: rtl/flash_page_ctl.sv
// Flash page programming controller top. It holds the control register
// (buffer enable, space select), routes data writes to the page buffer or
// to external RAM, and launches a program or buffer-clear on the two-write key.
// Assumes single-cycle write strobes and a synchronous active-low reset.
module flash_page_ctl
    import flash_pgm_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int PAGE_BYTES = 128,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W    = ADDR_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              sts_wr,
    input  logic [7:0]        sts_wdata,
    output logic [7:0]        sts_rdata,
    input  logic              dat_wr,
    input  logic [ADDR_W-1:0] dat_addr,
    input  logic [7:0]        dat_wdata,
    input  logic              xram_sel,
    output logic              xram_wr,
    output logic              cmd_valid,
    output logic [1:0]        cmd_space,
    output logic [PAGE_W-1:0] cmd_page,
    input  logic              cmd_ack,
    output logic              busy,
    input  logic [OFS_W-1:0]  rd_idx,
    output logic [7:0]        rd_data
);

    logic              buf_en_q;
    logic [1:0]        space_q;
    logic [PAGE_W-1:0] page_q;
    logic              launch, err_set;
    logic              buf_wr, buf_clr;
    logic              seq_err, loaded;
    logic              unused_bits;

    assign unused_bits = ^{ctl_wdata[3], sts_wdata[7:2], sts_wdata[0]};

    // Control register: lower nibble captured on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_en_q <= 1'b0;
            space_q  <= SPC_USER;
        end else if (ctl_wr) begin
            buf_en_q <= ctl_wdata[0];
            space_q  <= ctl_wdata[2:1];
        end
    end

    key_tracker u_keys (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_wr  (ctl_wr),
        .key     (ctl_wdata[7:4]),
        .busy    (busy),
        .launch  (launch),
        .seq_err (err_set)
    );

    // Data write routing: the buffer enable wins over external RAM.
    assign buf_wr  = dat_wr && buf_en_q && !busy && !launch;
    assign xram_wr = dat_wr && xram_sel && !buf_en_q;
    assign buf_clr = launch && (ctl_wdata[2:1] == SPC_BUFCLR);

    // Page number of the most recent accepted buffer write.
    always_ff @(posedge clk) begin
        if (!rst_n)      page_q <= '0;
        else if (buf_wr) page_q <= dat_addr[ADDR_W-1:OFS_W];
    end

    page_buffer #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (8)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_idx  (dat_addr[OFS_W-1:0]),
        .wr_data (dat_wdata),
        .clr     (buf_clr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    flash_status u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .err_set     (err_set),
        .launch      (launch),
        .sw_clr      (sts_wr && !sts_wdata[1]),
        .byte_loaded (buf_wr),
        .seq_err     (seq_err),
        .loaded      (loaded)
    );

    cmd_issuer #(
        .PAGE_W (PAGE_W)
    ) u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .space     (ctl_wdata[2:1]),
        .page_in   (page_q),
        .cmd_ack   (cmd_ack),
        .cmd_valid (cmd_valid),
        .cmd_space (cmd_space),
        .cmd_page  (cmd_page),
        .busy      (busy)
    );

    // Register readback.
    assign ctl_rdata = {5'b0, space_q, buf_en_q};
    assign sts_rdata = {6'b0, seq_err, loaded};

endmodule

// File: rtl/flash_page_ctl_chk.sv
// Assertion checker for flash_page_ctl, attached with bind below.
// Observes ports only; assumes synchronous active-low reset.
module flash_page_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] ctl_wdata,
    input logic [7:0] ctl_rdata,
    input logic [7:0] sts_rdata,
    input logic       xram_wr,
    input logic       cmd_valid,
    input logic [1:0] cmd_space,
    input logic       cmd_ack,
    input logic       busy
);

    a_r5_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r5_busy_with_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> busy);

    a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !cmd_ack) |=> busy);

    a_r4_launch_after_go: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> ($past(ctl_wr) && $past(ctl_wdata[7:4]) == 4'hA));

    a_r4_loaded_clear_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !sts_rdata[0]);

    a_r9_no_clear_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_space != 2'b11));

    a_r3_xram_only_unbuffered: assert property (@(posedge clk) disable iff (!rst_n)
        xram_wr |-> !ctl_rdata[0]);

    a_r7_status_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[7:2] == 6'b0);

    a_r13_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[7:3] == 5'b0);

endmodule

bind flash_page_ctl flash_page_ctl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .sts_rdata (sts_rdata),
    .xram_wr   (xram_wr),
    .cmd_valid (cmd_valid),
    .cmd_space (cmd_space),
    .cmd_ack   (cmd_ack),
    .busy      (busy)
);

// File: tb/tb_flash_page_ctl.sv
// Directed bench for flash_page_ctl: one task per scenario.
module tb_flash_page_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        sts_wr = 1'b0;
    logic [7:0]  sts_wdata = '0;
    logic [7:0]  sts_rdata;
    logic        dat_wr = 1'b0;
    logic [15:0] dat_addr = '0;
    logic [7:0]  dat_wdata = '0;
    logic        xram_sel = 1'b0;
    logic        xram_wr;
    logic        cmd_valid;
    logic [1:0]  cmd_space;
    logic [8:0]  cmd_page;
    logic        cmd_ack = 1'b0;
    logic        busy;
    logic [6:0]  rd_idx = '0;
    logic [7:0]  rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    flash_page_ctl dut (
        .clk (clk), .rst_n (rst_n),
        .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata), .ctl_rdata (ctl_rdata),
        .sts_wr (sts_wr), .sts_wdata (sts_wdata), .sts_rdata (sts_rdata),
        .dat_wr (dat_wr), .dat_addr (dat_addr), .dat_wdata (dat_wdata),
        .xram_sel (xram_sel), .xram_wr (xram_wr),
        .cmd_valid (cmd_valid), .cmd_space (cmd_space), .cmd_page (cmd_page),
        .cmd_ack (cmd_ack), .busy (busy),
        .rd_idx (rd_idx), .rd_data (rd_data)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic sts_write(input logic [7:0] v);
        @(negedge clk); sts_wr = 1'b1; sts_wdata = v;
        @(negedge clk); sts_wr = 1'b0;
    endtask

    task automatic data_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk); dat_wr = 1'b1; dat_addr = a; dat_wdata = d;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic ack_cmd();
        @(negedge clk); cmd_ack = 1'b1;
        @(negedge clk); cmd_ack = 1'b0;
    endtask

    task automatic peek(input logic [6:0] idx, output logic [7:0] v);
        rd_idx = idx; #0.1; v = rd_data;
    endtask

    task automatic t_reset();
        int bad = 0;
        logic [7:0] v;
        chk("R1 status", sts_rdata, 8'h00);
        chk("R1 control", ctl_rdata, 8'h00);
        chk("R1 busy/cmd", {busy, cmd_valid}, 2'b00);
        for (int i = 0; i < 128; i++) begin
            peek(7'(i), v);
            if (v !== 8'hFF) bad++;
        end
        chk("R1 erased bytes wrong", bad, 0);
    endtask

    task automatic t_buffer_load();
        logic [7:0] v;
        ctl_write(8'h01);
        chk("R13 control readback", ctl_rdata, 8'h01);
        data_write(16'h1285, 8'h3C);
        data_write(16'h1280, 8'h11);
        peek(7'd5, v); chk("R2 byte at 05", v, 8'h3C);
        peek(7'd0, v); chk("R2 byte at 00", v, 8'h11);
        chk("R2 loaded flag", sts_rdata, 8'h01);
    endtask

    task automatic t_xram_precedence();
        logic [7:0] v;
        @(negedge clk); xram_sel = 1'b1; dat_wr = 1'b1; dat_addr = 16'h1287; dat_wdata = 8'h77;
        #0.5 chk("R3 no xram write with buffer enabled", xram_wr, 1'b0);
        @(negedge clk); dat_wr = 1'b0;
        peek(7'd7, v); chk("R3 buffer wins", v, 8'h77);
        ctl_write(8'h00);
        @(negedge clk); dat_wr = 1'b1; dat_addr = 16'h1288; dat_wdata = 8'h99;
        #0.5 chk("R3 xram write with buffer disabled", xram_wr, 1'b1);
        @(negedge clk); dat_wr = 1'b0; xram_sel = 1'b0;
        peek(7'd8, v); chk("R3 buffer untouched", v, 8'hFF);
        ctl_write(8'h01);
    endtask

    task automatic t_launch_user();
        logic [7:0] v;
        ctl_write(8'h51);
        ctl_write(8'hA1);
        chk("R4 cmd_valid", cmd_valid, 1'b1);
        chk("R4 space", cmd_space, 2'b00);
        chk("R4 page", cmd_page, 9'h025);
        chk("R4 loaded cleared, no error", sts_rdata, 8'h00);
        chk("R5 busy on command", busy, 1'b1);
        peek(7'd5, v); chk("R4 byte readable by target", v, 8'h3C);
        @(negedge clk);
        chk("R5 pulse one cycle", {cmd_valid, busy}, 2'b01);
        data_write(16'h1289, 8'h55);
        peek(7'd9, v); chk("R11 write ignored while busy", v, 8'hFF);
        chk("R11 no loaded flag while busy", sts_rdata[0], 1'b0);
        ctl_write(8'h51);
        ctl_write(8'hA1);
        chk("R11 refused launch no cmd", cmd_valid, 1'b0);
        chk("R11 refused launch error", sts_rdata, 8'h02);
        chk("R5 still busy before ack", busy, 1'b1);
        ack_cmd();
        chk("R5 busy drops after ack", busy, 1'b0);
    endtask

    task automatic t_sw_clear();
        sts_write(8'h02);
        chk("R7 bit1 set keeps error", sts_rdata, 8'h02);
        sts_write(8'hFD);
        chk("R7 clear error, no flag set", sts_rdata, 8'h00);
    endtask

    task automatic t_order_error();
        ctl_write(8'hA1);
        chk("R6 unarmed go sets error", sts_rdata[1], 1'b1);
        chk("R6 no command", {cmd_valid, busy}, 2'b00);
        sts_write(8'h00);
        ctl_write(8'h51);
        ctl_write(8'h31);
        chk("R10 broken sequence error", sts_rdata[1], 1'b1);
        ctl_write(8'hA1);
        chk("R10 disarmed after break", cmd_valid, 1'b0);
        ctl_write(8'h51);
        ctl_write(8'h51);
        ctl_write(8'hA5);
        chk("R10 restart launches", cmd_valid, 1'b1);
        chk("R4 security space", cmd_space, 2'b10);
        chk("R8 success clears error", sts_rdata[1], 1'b0);
        chk("R13 control after go write", ctl_rdata, 8'h05);
        ack_cmd();
    endtask

    task automatic t_buffer_reset();
        int bad = 0;
        logic [7:0] v;
        ctl_write(8'h01);
        data_write(16'h0300, 8'h42);
        chk("R2 loaded before clear", sts_rdata[0], 1'b1);
        ctl_write(8'h57);
        ctl_write(8'hA7);
        chk("R9 no command, not busy", {cmd_valid, busy}, 2'b00);
        chk("R9 flags cleared", sts_rdata, 8'h00);
        for (int i = 0; i < 128; i++) begin
            peek(7'(i), v);
            if (v !== 8'hFF) bad++;
        end
        chk("R9 bytes not FF", bad, 0);
    endtask

    task automatic t_same_cycle();
        logic [7:0] v;
        ctl_write(8'h03);
        data_write(16'h0402, 8'h5A);
        ctl_write(8'h53);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 8'hA3;
        dat_wr = 1'b1; dat_addr = 16'h0483; dat_wdata = 8'h66;
        @(negedge clk); ctl_wr = 1'b0; dat_wr = 1'b0;
        chk("R12 command issued", cmd_valid, 1'b1);
        chk("R12 extra-row space", cmd_space, 2'b01);
        chk("R12 page from earlier write", cmd_page, 9'h008);
        peek(7'd3, v); chk("R12 same-cycle byte dropped", v, 8'hFF);
        peek(7'd2, v); chk("R12 earlier byte kept", v, 8'h5A);
        chk("R12 loaded flag clear", sts_rdata[0], 1'b0);
        ack_cmd();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_buffer_load();
        t_xram_precedence();
        t_launch_user();
        t_sw_clear();
        t_order_error();
        t_buffer_reset();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule